// File: doc/BRIEF.md
# Seeded Random Number Generator with Automatic Reseed

This block is a command-driven random-number source behind a small 32-bit register interface. Software writes a command word to start either a seeding pass or a generate pass. It watches a status word that shows whether the block has been seeded and whether it is busy generating or reseeding. When a result is ready, it reads up to eight 32-bit output words. Completion events are latched in an interrupt-status word that software clears by writing ones. An interrupt line is raised when the global enable and the enable for a pending event are both set.

Every pass takes a fixed number of cycles, so the timing seen at the bus matches that of a real generator. A set of xorshift lanes stands in for the deterministic random bit generator and its entropy source. After reset the block seeds itself before it accepts work. It also counts the 16-byte units it has produced and starts a reseed once a programmable limit is reached.

Top module: `seeded_rng`

## Requirements
- R1: After reset the block reseeds on its own: status bit 31 (reseeding) is 1 and bit 9 (seeded) is 0. When the pass ends, bit 31 is 0, bit 9 is 1, and interrupt-status bit 1 (seed done) is 1. Once set, seeded never clears.
- R2: The word at offset 0xF0 reads 0x000046BC. An unmapped offset such as 0x40 reads 0.
- R3: Writing 1 to offset 0x00 while idle and seeded starts a generate pass. With mode 1 at offset 0x08 (256 bits), status bit 30 is 1 for exactly 1024 cycles, counted from the write edge. On the edge that ends the pass, interrupt-status bit 0 (random ready) sets and new data appears in words 0x20 to 0x3C.
- R4: With mode 0 (128 bits), the generate pass lasts 512 cycles. Words 0x20 to 0x2C are loaded and words 0x30 to 0x3C read 0.
- R5: Two successive generate passes give different output words. The output words hold their value between passes.
- R6: Interrupt-status at 0x14 is write-one-to-clear: a 1 in bit 0 or bit 1 clears that bit, and a 0 leaves it unchanged.
- R7: Writing 2 to offset 0x00 while idle starts a seed pass. Status bit 31 is 1 for exactly 512 cycles, then interrupt-status bit 1 sets.
- R8: A generate or seed command written while a pass is running is ignored, and the running pass keeps its original end time. Writing 0 (no operation) has no effect.
- R9: Offset 0x60 holds a limit N of 16-byte units; a 128-bit pass counts 1 unit and a 256-bit pass counts 2. When the count reaches at least N at the end of a generate pass, a reseed pass (bit 31) starts on the next cycle and the count restarts. N = 0 (the reset value) disables the automatic reseed.
- R10: The interrupt-enable register at 0x10 has bit 31 as the global enable, bit 1 for seed done and bit 0 for random ready. irq is 1 only when the global enable is set and some enabled interrupt-status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a command that arrives while a pass is already running. The stimulus for that is timed against the exact pass length. The bench issues a second generate a known number of cycles into a generate pass, and a generate midway through a seed pass. It then checks that the busy bits drop on the original edge and that no extra ready event appears. The automatic reseed needs a nonzero limit and several complete passes, so the bench programs a small limit and watches the reseeding bit on the cycle right after the last pass ends.

// File: rtl/rng_pkg.sv
package rng_pkg;

  localparam int unsigned REG_W = 32;

  localparam logic [7:0] OFS_CMD     = 8'h00;
  localparam logic [7:0] OFS_STATUS  = 8'h04;
  localparam logic [7:0] OFS_MODE    = 8'h08;
  localparam logic [7:0] OFS_IEN     = 8'h10;
  localparam logic [7:0] OFS_ISTAT   = 8'h14;
  localparam logic [7:0] OFS_LIMIT   = 8'h60;
  localparam logic [7:0] OFS_VERSION = 8'hF0;
  localparam logic [2:0] OFS_OUT_HI  = 3'b001;

  localparam logic [31:0] VERSION_WORD = 32'h0000_46BC;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_GEN  = 2'd1,
    OP_SEED = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_GEN,
    PH_SEED
  } phase_e;

  function automatic logic [31:0] xs32(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [31:0] rotl7(input logic [31:0] v);
    return {v[24:0], v[31:25]};
  endfunction

endpackage

// File: rtl/rng_seq.sv
module rng_seq
  import rng_pkg::*;
#(
  parameter int unsigned GEN_LAT_WIDE = 1024,
  parameter int unsigned SEED_LAT     = 512,
  parameter int unsigned LIMIT_W      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic               wide_mode,
  input  logic [LIMIT_W-1:0] unit_limit,
  output logic               generating,
  output logic               reseeding,
  output logic               seeded,
  output logic               gen_done,
  output logic               seed_done,
  output logic               gen_wide
);

  localparam int unsigned GEN_LAT_NARROW = GEN_LAT_WIDE / 2;
  localparam int unsigned MAX_LAT = (GEN_LAT_WIDE > SEED_LAT) ? GEN_LAT_WIDE : SEED_LAT;
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_W1 = CNT_W'(GEN_LAT_WIDE - 1);
  localparam logic [CNT_W-1:0] LAT_N1 = CNT_W'(GEN_LAT_NARROW - 1);
  localparam logic [CNT_W-1:0] LAT_S1 = CNT_W'(SEED_LAT - 1);

  phase_e             ph_q, ph_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic [LIMIT_W-1:0] units_q, units_nx;
  logic               seeded_q, seeded_nx;
  logic               wide_q, wide_nx;
  logic               gdone, sdone;
  logic [LIMIT_W:0]   units_sum;

  always_comb begin
    ph_nx     = ph_q;
    cnt_nx    = cnt_q;
    units_nx  = units_q;
    seeded_nx = seeded_q;
    wide_nx   = wide_q;
    gdone     = 1'b0;
    sdone     = 1'b0;
    units_sum = {1'b0, units_q} + (wide_q ? (LIMIT_W+1)'(2) : (LIMIT_W+1)'(1));
    case (ph_q)
      PH_IDLE: begin
        if (cmd_valid && cmd_op == OP_GEN && seeded_q) begin
          ph_nx   = PH_GEN;
          cnt_nx  = wide_mode ? LAT_W1 : LAT_N1;
          wide_nx = wide_mode;
        end else if (cmd_valid && cmd_op == OP_SEED) begin
          ph_nx    = PH_SEED;
          cnt_nx   = LAT_S1;
          units_nx = '0;
        end
      end
      PH_GEN: begin
        if (cnt_q == '0) begin
          gdone = 1'b1;
          if (unit_limit == '0) begin
            ph_nx    = PH_IDLE;
            units_nx = '0;
          end else if (units_sum >= {1'b0, unit_limit}) begin
            ph_nx    = PH_SEED;
            cnt_nx   = LAT_S1;
            units_nx = '0;
          end else begin
            ph_nx    = PH_IDLE;
            units_nx = units_sum[LIMIT_W-1:0];
          end
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
      PH_SEED: begin
        if (cnt_q == '0) begin
          sdone     = 1'b1;
          ph_nx     = PH_IDLE;
          seeded_nx = 1'b1;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_SEED;
      cnt_q    <= LAT_S1;
      units_q  <= '0;
      seeded_q <= 1'b0;
      wide_q   <= 1'b0;
    end else begin
      ph_q     <= ph_nx;
      cnt_q    <= cnt_nx;
      units_q  <= units_nx;
      seeded_q <= seeded_nx;
      wide_q   <= wide_nx;
    end
  end

  assign generating = (ph_q == PH_GEN);
  assign reseeding  = (ph_q == PH_SEED);
  assign seeded     = seeded_q;
  assign gen_done   = gdone;
  assign seed_done  = sdone;
  assign gen_wide   = wide_q;

  assert_one_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({generating, reseeding}));

  assert_seeded_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seeded |=> seeded);

  assert_seeded_after_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seeded) |-> $past(reseeding));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_LAT - 1));

endmodule

// File: rtl/rng_mix.sv
module rng_mix
  import rng_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stir,
  input  logic                   capture,
  input  logic                   wide,
  output logic [LANES*REG_W-1:0] words
);

  localparam int unsigned HALF = LANES / 2;

  logic [REG_W-1:0] lane_q [LANES];
  logic [REG_W-1:0] out_q  [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [REG_W-1:0] LANE_INIT =
      (32'h9E37_79B9 + 32'(i) * 32'h7F4A_7C15) | 32'h1;
    localparam int unsigned NEXT = (i + 1) % LANES;
    logic [REG_W-1:0] lane_nx, out_nx;

    always_comb begin
      lane_nx = stir ? xs32(xs32(lane_q[i])) : xs32(lane_q[i]);
      if (i >= HALF && !wide) out_nx = '0;
      else                    out_nx = lane_q[i] ^ rotl7(lane_q[NEXT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[i] <= LANE_INIT;
      end else begin
        lane_q[i] <= lane_nx;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[i] <= '0;
      end else if (capture) begin
        out_q[i] <= out_nx;
      end
    end

    assign words[i*REG_W +: REG_W] = out_q[i];
  end

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(words));

endmodule

// File: rtl/seeded_rng.sv
module seeded_rng
  import rng_pkg::*;
#(
  parameter int unsigned GEN_LAT_WIDE = 1024,
  parameter int unsigned SEED_LAT     = 512,
  parameter int unsigned OUT_WORDS    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);

  localparam int unsigned IDX_W = $clog2(OUT_WORDS);

  logic        mode_q, mode_nx;
  logic        ie_glb_q, ie_seed_q, ie_rdy_q;
  logic        ie_glb_nx, ie_seed_nx, ie_rdy_nx;
  logic [1:0]  ist_q, ist_nx;
  logic [31:0] limit_q, limit_nx;

  logic wr, cmd_valid;
  logic generating, reseeding, seeded, gen_done, seed_done, gen_wide;
  logic [OUT_WORDS*REG_W-1:0] words;

  assign wr        = bus_en && bus_we;
  assign cmd_valid = wr && (bus_addr == OFS_CMD);

  rng_seq #(
    .GEN_LAT_WIDE (GEN_LAT_WIDE),
    .SEED_LAT     (SEED_LAT),
    .LIMIT_W      (32)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (bus_wdata[1:0] & {2{bus_wdata[31:2] == '0}}),
    .wide_mode  (mode_q),
    .unit_limit (limit_q),
    .generating (generating),
    .reseeding  (reseeding),
    .seeded     (seeded),
    .gen_done   (gen_done),
    .seed_done  (seed_done),
    .gen_wide   (gen_wide)
  );

  rng_mix #(
    .LANES (OUT_WORDS)
  ) mix_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stir    (seed_done),
    .capture (gen_done),
    .wide    (gen_wide),
    .words   (words)
  );

  always_comb begin
    mode_nx    = mode_q;
    ie_glb_nx  = ie_glb_q;
    ie_seed_nx = ie_seed_q;
    ie_rdy_nx  = ie_rdy_q;
    limit_nx   = limit_q;
    ist_nx     = ist_q;
    if (wr) begin
      case (bus_addr)
        OFS_MODE:  mode_nx = bus_wdata[0];
        OFS_IEN: begin
          ie_glb_nx  = bus_wdata[31];
          ie_seed_nx = bus_wdata[1];
          ie_rdy_nx  = bus_wdata[0];
        end
        OFS_ISTAT: ist_nx = ist_q & ~bus_wdata[1:0];
        OFS_LIMIT: limit_nx = bus_wdata;
        default: ;
      endcase
    end
    if (gen_done)  ist_nx[0] = 1'b1;
    if (seed_done) ist_nx[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      ie_glb_q  <= 1'b0;
      ie_seed_q <= 1'b0;
      ie_rdy_q  <= 1'b0;
      ist_q     <= 2'b00;
      limit_q   <= '0;
    end else begin
      mode_q    <= mode_nx;
      ie_glb_q  <= ie_glb_nx;
      ie_seed_q <= ie_seed_nx;
      ie_rdy_q  <= ie_rdy_nx;
      ist_q     <= ist_nx;
      limit_q   <= limit_nx;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7:5] == OFS_OUT_HI && bus_addr[1:0] == 2'b00) begin
      bus_rdata = words[IDX_W'(bus_addr[4:2])*REG_W +: REG_W];
    end else begin
      case (bus_addr)
        OFS_STATUS:  bus_rdata = {reseeding, generating, 20'b0, seeded, 9'b0};
        OFS_MODE:    bus_rdata = {31'b0, mode_q};
        OFS_IEN:     bus_rdata = {ie_glb_q, 29'b0, ie_seed_q, ie_rdy_q};
        OFS_ISTAT:   bus_rdata = {30'b0, ist_q};
        OFS_LIMIT:   bus_rdata = limit_q;
        OFS_VERSION: bus_rdata = VERSION_WORD;
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign irq = ie_glb_q && ((ie_rdy_q && ist_q[0]) || (ie_seed_q && ist_q[1]));

  assert_ready_from_gen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist_q[0]) |-> $fell(generating));

  assert_ready_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ist_q[0]) |-> $past(wr && bus_addr == OFS_ISTAT && bus_wdata[0]));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_q == 2'b00) |-> !irq);

endmodule

// File: tb/seeded_rng_tb.sv
`timescale 1ns/1ps
module seeded_rng_tb_top;

  localparam int GEN_W  = 1024;
  localparam int GEN_N  = 512;
  localparam int SEEDL  = 512;
  localparam logic [31:0] B_SEEDED = 32'h0000_0200;
  localparam logic [31:0] B_GEN    = 32'h4000_0000;
  localparam logic [31:0] B_RESEED = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] prev_words [8];

  always #2.5 clk = ~clk;

  seeded_rng dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_addr = 8'h00;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h04, s);
      if ((s & (B_GEN | B_RESEED)) == 0) break;
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset_boot();
    logic [31:0] s;
    rd(8'h04, s);
    check("R1 boot reseeding", s & (B_RESEED | B_SEEDED), B_RESEED);
    rd(8'h14, s);
    check("R1 istat zero in boot", s, 32'h0);
    wait_idle();
    rd(8'h04, s);
    check("R1 seeded after boot", s, B_SEEDED);
    rd(8'h14, s);
    check("R1 seed done set", s, 32'h2);
    rd(8'hF0, s);
    check("R2 version", s, 32'h0000_46BC);
    rd(8'h40, s);
    check("R2 unmapped", s, 32'h0);
  endtask

  task automatic t_irq_w1c();
    logic [31:0] s;
    check("R10 irq off with no enables", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h0000_0002);
    check("R10 irq needs global", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0002);
    check("R10 irq on", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h8000_0001);
    check("R10 irq masked by bit enable", {31'b0, irq}, 32'h0);
    wr(8'h14, 32'h0000_0001);
    rd(8'h14, s);
    check("R6 zero bit leaves seed done", s, 32'h2);
    wr(8'h14, 32'h0000_0002);
    rd(8'h14, s);
    check("R6 one bit clears", s, 32'h0);
  endtask

  task automatic run_gen(input int lat, input string tag);
    logic [31:0] s;
    wr(8'h00, 32'h1);
    rd(8'h04, s);
    check({tag, " generating starts"}, s & B_GEN, B_GEN);
    repeat (lat - 1) @(posedge clk);
    #1;
    rd(8'h04, s);
    check({tag, " generating at last cycle"}, s & B_GEN, B_GEN);
    @(posedge clk); #1;
    rd(8'h04, s);
    check({tag, " generating ends"}, s & B_GEN, 32'h0);
    rd(8'h14, s);
    check({tag, " ready set"}, s & 32'h1, 32'h1);
  endtask

  task automatic t_gen_wide();
    logic [31:0] s;
    int nz;
    wr(8'h10, 32'h8000_0001);
    wr(8'h08, 32'h1);
    run_gen(GEN_W, "R3");
    check("R10 irq on ready", {31'b0, irq}, 32'h1);
    rd(8'h04, s);
    check("R9 no reseed with limit zero", s & B_RESEED, 32'h0);
    nz = 0;
    for (int i = 0; i < 8; i++) begin
      rd(8'h20 + 8'(i * 4), prev_words[i]);
      if (prev_words[i] != 0) nz++;
    end
    check("R3 wide output loaded", 32'(nz > 4), 32'h1);
    wr(8'h14, 32'h1);
    check("R10 irq off after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_gen_narrow();
    logic [31:0] s;
    int nz, diff;
    wr(8'h08, 32'h0);
    run_gen(GEN_N, "R4");
    nz = 0; diff = 0;
    for (int i = 0; i < 4; i++) begin
      rd(8'h20 + 8'(i * 4), s);
      if (s != 0) nz++;
      if (s != prev_words[i]) diff++;
    end
    check("R4 low words loaded", 32'(nz > 1), 32'h1);
    check("R5 new words differ", 32'(diff == 4), 32'h1);
    for (int i = 4; i < 8; i++) begin
      rd(8'h20 + 8'(i * 4), s);
      check("R4 high word zero", s, 32'h0);
    end
    repeat (20) @(posedge clk);
    #1;
    rd(8'h20, s);
    rd(8'h20, prev_words[0]);
    check("R5 words hold", s, prev_words[0]);
    wr(8'h14, 32'h1);
  endtask

  task automatic t_ignore();
    logic [31:0] s;
    wr(8'h00, 32'h0);
    rd(8'h04, s);
    check("R8 nop no effect", s, B_SEEDED);
    wr(8'h08, 32'h1);
    wr(8'h00, 32'h1);
    repeat (100) @(posedge clk);
    #1;
    wr(8'h00, 32'h1);
    wr(8'h00, 32'h2);
    repeat (GEN_W - 1 - 102) @(posedge clk);
    #1;
    rd(8'h04, s);
    check("R8 pass keeps running", s & (B_GEN | B_RESEED), B_GEN);
    @(posedge clk); #1;
    rd(8'h04, s);
    check("R8 original end time", s & (B_GEN | B_RESEED), 32'h0);
    wr(8'h14, 32'h3);
    wr(8'h00, 32'h2);
    rd(8'h04, s);
    check("R7 seed starts", s & B_RESEED, B_RESEED);
    repeat (200) @(posedge clk);
    #1;
    wr(8'h00, 32'h1);
    repeat (SEEDL - 1 - 201) @(posedge clk);
    #1;
    rd(8'h04, s);
    check("R7 seeding at last cycle", s & (B_GEN | B_RESEED), B_RESEED);
    @(posedge clk); #1;
    rd(8'h04, s);
    check("R8 gen during seed ignored", s & (B_GEN | B_RESEED), 32'h0);
    rd(8'h14, s);
    check("R7 seed done, no ready", s, 32'h2);
    wr(8'h14, 32'h3);
  endtask

  task automatic t_auto_reseed();
    logic [31:0] s;
    wr(8'h60, 32'd2);
    wr(8'h08, 32'h0);
    run_gen(GEN_N, "R9 first");
    rd(8'h04, s);
    check("R9 below limit no reseed", s & B_RESEED, 32'h0);
    run_gen(GEN_N, "R9 second");
    rd(8'h04, s);
    check("R9 reseed at limit", s & B_RESEED, B_RESEED);
    wait_idle();
    rd(8'h14, s);
    check("R9 reseed sets seed done", s & 32'h2, 32'h2);
    wr(8'h14, 32'h3);
    wr(8'h08, 32'h1);
    run_gen(GEN_W, "R9 wide");
    rd(8'h04, s);
    check("R9 wide pass counts two", s & B_RESEED, B_RESEED);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset_boot();
    t_irq_w1c();
    t_gen_wide();
    t_gen_narrow();
    t_ignore();
    t_auto_reseed();
    finish_run();
  end

endmodule